// File: doc/BRIEF.md
# Low-Segment Write Lock

This block sits in the write path between a processor core and its main RAM. It guards a fixed low address window, from address zero up to and including a build-time bound. After reset every write reaches the RAM, so start-up code such as a loader can be stored in the low window. When the instruction decoder issues a one-cycle lock command, a sticky lock is armed. From then on, any write that lands in the guarded window is dropped and reported on a one-cycle violation pulse. A status unit can encode that pulse as an illegal-access fault.

The lock can only be released by reset. The window can therefore be filled exactly once per reset. Writes above the bound are never affected. Address, data and the gated write enable come out of registers one clock after the request, which keeps them aligned with each other and suits a block-RAM write port. Reads do not pass through this block and are never gated.

Top module: `wprot_guard`

## Requirements
- R1: While `rst` is high and on the first cycle after its release, `ram_we_o` and `viol_o` are 0 and `ram_addr_o`/`ram_data_o` are 0. A write requested during reset is not forwarded.
- R2: While the lock is clear, a write (`wr_en_i`=1) to any address, including every address in 0..`PROT_TOP`, gives `ram_we_o`=1 and `viol_o`=0 one clock later.
- R3: A one-cycle `lock_cmd_i` pulse arms the lock at that clock edge. A write in the same cycle as the pulse still passes. Every later write to an address in 0..`PROT_TOP` gives `ram_we_o`=0 one clock later.
- R4: A write that the lock blocks gives `viol_o`=1 for exactly the one cycle in which `ram_we_o` would otherwise have been 1. `viol_o` and `ram_we_o` are never 1 together.
- R5: The comparison is inclusive. Address `PROT_TOP` is guarded and `PROT_TOP`+1 is not. Writes above `PROT_TOP` pass whether or not the lock is set.
- R6: Once armed, the lock stays set until reset. A further `lock_cmd_i` has no effect. After a reset, writes to the window pass again.
- R7: A cycle with `wr_en_i`=0 gives `ram_we_o`=0 and `viol_o`=0 one clock later, whatever the address and lock state.
- R8: On every requested write, `ram_addr_o` and `ram_data_o` carry that request's address and data one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_addr_i | input | ADDR_W | Write address from the core |
| wr_data_i | input | DATA_W | Write data from the core |
| wr_en_i | input | 1 | Write request from the core |
| lock_cmd_i | input | 1 | One-cycle lock command from the decoder |
| ram_addr_o | output | ADDR_W | Registered write address to RAM |
| ram_data_o | output | DATA_W | Registered write data to RAM |
| ram_we_o | output | 1 | Registered, gated write enable to RAM |
| viol_o | output | 1 | One-cycle pulse for a blocked write |

## Verification
The checker watches these properties on every cycle:
- the lock stays set once armed and a command always arms it;
- a guarded write while locked is blocked and flagged;
- an open write before locking, or a write above the bound, passes;
- idle cycles stay quiet;
- the address is forwarded;
- `viol_o` and `ram_we_o` are never high together.

Only the bench scenarios can show some behaviours. These are the exact boundary addresses at the bound and one above it, and a write in the same cycle as the lock command still passing. They also include the reset state with a write pending, and the lock clearing after a mid-run reset. These depend on particular sequences rather than on a per-cycle relation.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  localparam int          WPROT_DEF_ADDR_W = 16;
  localparam int          WPROT_DEF_DATA_W = 16;
  localparam logic [31:0] WPROT_DEF_TOP    = 32'h0000_007F;
  // code a status unit may report for a blocked write
  localparam logic [2:0]  WPROT_FAULT_CODE = 3'b001;
endpackage

// File: rtl/wprot_lock.sv
module wprot_lock (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  output logic locked_o
);
  logic lock_q;

  // sticky: only reset clears it
  always_ff @(posedge clk) begin
    if (rst) lock_q <= 1'b0;
    else if (arm_i) lock_q <= 1'b1;
  end

  assign locked_o = lock_q;
endmodule

// File: rtl/wprot_range.sv
module wprot_range #(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] PROT_TOP = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam logic [ADDR_W-1:0] ALL_ONES = '1;

  generate
    if (PROT_TOP == ALL_ONES) begin : g_full
      // the whole space is guarded: no comparator needed
      logic unused_addr;
      assign unused_addr = ^addr_i;
      assign hit_o = 1'b1;
    end else begin : g_cmp
      assign hit_o = (addr_i <= PROT_TOP);
    end
  endgenerate
endmodule

// File: rtl/wprot_gate.sv
module wprot_gate #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              wen_i,
  input  logic              block_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              we_o,
  output logic              viol_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              we_q;
  logic              viol_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_q   <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      we_q   <= wen_i & ~block_i;
      viol_q <= wen_i & block_i;
    end
  end

  // address/data capture only on a request, keeping RAM port stable
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (wen_i) begin
      addr_q <= addr_i;
      data_q <= data_i;
    end
  end

  assign addr_o = addr_q;
  assign data_o = data_q;
  assign we_o   = we_q;
  assign viol_o = viol_q;
endmodule

// File: rtl/wprot_guard.sv
module wprot_guard
  import wprot_pkg::*;
#(
  parameter int                ADDR_W   = WPROT_DEF_ADDR_W,
  parameter int                DATA_W   = WPROT_DEF_DATA_W,
  parameter logic [ADDR_W-1:0] PROT_TOP = ADDR_W'(WPROT_DEF_TOP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_en_i,
  input  logic              lock_cmd_i,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_data_o,
  output logic              ram_we_o,
  output logic              viol_o
);
  logic lock_q;
  logic in_win;
  logic block;

  wprot_lock lock_i (
    .clk      (clk),
    .rst      (rst),
    .arm_i    (lock_cmd_i),
    .locked_o (lock_q)
  );

  wprot_range #(.ADDR_W(ADDR_W), .PROT_TOP(PROT_TOP)) range_i (
    .addr_i (wr_addr_i),
    .hit_o  (in_win)
  );

  // lock state before this edge decides; same-cycle command does not block
  assign block = lock_q & in_win;

  wprot_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) gate_i (
    .clk     (clk),
    .rst     (rst),
    .addr_i  (wr_addr_i),
    .data_i  (wr_data_i),
    .wen_i   (wr_en_i),
    .block_i (block),
    .addr_o  (ram_addr_o),
    .data_o  (ram_data_o),
    .we_o    (ram_we_o),
    .viol_o  (viol_o)
  );
endmodule

// File: rtl/wprot_guard_chk.sv
module wprot_guard_chk #(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] PROT_TOP = '0
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              wr_en_i,
  input logic              lock_cmd_i,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic              ram_we_o,
  input logic              viol_o,
  input logic              lock_q
);
  AST_OPEN_PASS: assert property (@(posedge clk) disable iff (rst) (!lock_q && wr_en_i) |=> (ram_we_o && !viol_o)); // R2
  AST_LOCK_ARM: assert property (@(posedge clk) disable iff (rst) lock_cmd_i |=> lock_q); // R3
  AST_GUARD_BLOCK: assert property (@(posedge clk) disable iff (rst) (lock_q && wr_en_i && wr_addr_i <= PROT_TOP) |=> (!ram_we_o && viol_o)); // R3
  AST_WE_VIOL_EXCL: assert property (@(posedge clk) disable iff (rst) !(ram_we_o && viol_o)); // R4
  AST_HIGH_PASS: assert property (@(posedge clk) disable iff (rst) (wr_en_i && wr_addr_i > PROT_TOP) |=> ram_we_o); // R5
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst) lock_q |=> lock_q); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !wr_en_i |=> (!ram_we_o && !viol_o)); // R7
  AST_ADDR_FWD: assert property (@(posedge clk) disable iff (rst) wr_en_i |=> (ram_addr_o == $past(wr_addr_i))); // R8
endmodule

bind wprot_guard wprot_guard_chk #(.ADDR_W(ADDR_W), .PROT_TOP(PROT_TOP)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .wr_addr_i  (wr_addr_i),
  .wr_en_i    (wr_en_i),
  .lock_cmd_i (lock_cmd_i),
  .ram_addr_o (ram_addr_o),
  .ram_we_o   (ram_we_o),
  .viol_o     (viol_o),
  .lock_q     (lock_q)
);

// File: tb/wprot_guard_tb_top.sv
module wprot_guard_tb_top;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int NV = 12;
  // vector: {lock_cmd, wen, addr[15:0], data[15:0], exp_we, exp_viol}
  localparam logic [35:0] VEC [NV] = '{
    {1'b0, 1'b1, 16'h0000, 16'hAAAA, 1'b1, 1'b0}, // R2 bottom
    {1'b0, 1'b1, 16'h007F, 16'h1234, 1'b1, 1'b0}, // R2 bound, open
    {1'b0, 1'b1, 16'h0080, 16'h5555, 1'b1, 1'b0}, // R5
    {1'b1, 1'b1, 16'h0010, 16'h0F0F, 1'b1, 1'b0}, // R3 same-cycle write passes
    {1'b0, 1'b1, 16'h0010, 16'hDEAD, 1'b0, 1'b1}, // R3 R4 blocked
    {1'b0, 1'b1, 16'h007F, 16'hBEEF, 1'b0, 1'b1}, // R5 bound guarded
    {1'b0, 1'b1, 16'h0080, 16'hC0DE, 1'b1, 1'b0}, // R5 bound+1 passes
    {1'b0, 1'b1, 16'hFFFF, 16'h7777, 1'b1, 1'b0}, // R5 top of space
    {1'b0, 1'b0, 16'h0005, 16'h9999, 1'b0, 1'b0}, // R7 idle in window
    {1'b1, 1'b1, 16'h0020, 16'h1111, 1'b0, 1'b1}, // R6 re-command no effect
    {1'b0, 1'b1, 16'h0000, 16'h2222, 1'b0, 1'b1}, // R6 still locked
    {1'b0, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0}  // R4 R7 pulse ends
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] wr_addr_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic          wr_en_i = 1'b0;
  logic          lock_cmd_i = 1'b0;
  logic [AW-1:0] ram_addr_o;
  logic [DW-1:0] ram_data_o;
  logic          ram_we_o;
  logic          viol_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  wprot_guard dut_i (
    .clk(clk), .rst(rst), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .wr_en_i(wr_en_i), .lock_cmd_i(lock_cmd_i), .ram_addr_o(ram_addr_o),
    .ram_data_o(ram_data_o), .ram_we_o(ram_we_o), .viol_o(viol_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic lc, input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    lock_cmd_i = lc;
    wr_en_i    = we;
    wr_addr_i  = a;
    wr_data_i  = d;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    // R1: reset with a write pending
    drive(1'b0, 1'b1, 16'h0003, 16'h4444);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 we in reset", 32'(ram_we_o), 32'd0);
    chk("R1 viol in reset", 32'(viol_o), 32'd0);
    chk("R1 addr in reset", 32'(ram_addr_o), 32'd0);
    chk("R1 data in reset", 32'(ram_data_o), 32'd0);
    drive(1'b0, 1'b0, '0, '0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R1 we after release", 32'(ram_we_o), 32'd0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][35], VEC[i][34], VEC[i][33:18], VEC[i][17:2]);
      @(posedge clk);
      @(negedge clk);
      chk($sformatf("R2/R3/R5/R6/R7 we vec%0d", i), 32'(ram_we_o), 32'(VEC[i][1]));
      chk($sformatf("R4 viol vec%0d", i), 32'(viol_o), 32'(VEC[i][0]));
      if (VEC[i][1]) begin
        chk($sformatf("R8 addr vec%0d", i), 32'(ram_addr_o), 32'(VEC[i][33:18]));
        chk($sformatf("R8 data vec%0d", i), 32'(ram_data_o), 32'(VEC[i][17:2]));
      end
    end

    // R4: a blocked write followed by an open write: pulse lasts one cycle
    drive(1'b0, 1'b1, 16'h0001, 16'h0101);
    @(posedge clk);
    @(negedge clk);
    chk("R4 viol set", 32'(viol_o), 32'd1);
    drive(1'b0, 1'b1, 16'h0100, 16'h0202);
    @(posedge clk);
    @(negedge clk);
    chk("R4 viol one cycle", 32'(viol_o), 32'd0);
    chk("R4 we follows", 32'(ram_we_o), 32'd1);

    // R6: reset clears the lock
    drive(1'b0, 1'b0, '0, '0);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    drive(1'b0, 1'b1, 16'h0010, 16'h3333);
    @(posedge clk);
    @(negedge clk);
    chk("R6 window open after reset", 32'(ram_we_o), 32'd1);
    chk("R6 no viol after reset", 32'(viol_o), 32'd0);
    chk("R8 data after reset", 32'(ram_data_o), 32'h3333);
    drive(1'b0, 1'b0, '0, '0);
    @(posedge clk);
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule